// File: doc/BRIEF.md
# Four-Mode Serial Port Core

This core is a serial port with four operating modes, picked by a two-bit mode input. Mode 0 is a synchronous shift register. The core drives a shift clock on `txd` and moves data on the `rxd` pin, which is split into `rxd_in`, `rxd_out` and `rxd_oe` so the pad can be bidirectional. Mode 1 is an asynchronous link with 8 data bits. Modes 2 and 3 are asynchronous with 9 data bits. The 9th transmitted bit comes from `tx_bit9`, and the 9th received bit is captured into `rx_bit9`.

The bit rate depends on the mode:

| Mode | Bit period |
|------|------------|
| 0 | 16 clocks |
| 2 | 16 or 32 clocks, chosen by `rate_half` |
| 1 and 3 | 16 pulses of the external `ext_tick` input |

The same 16-step count per bit serves every mode. The asynchronous receiver oversamples each bit 16 times, rejects false start bits, and votes on three samples at mid-bit.

The transmit side is a valid/ready input stream. A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while a frame is in progress. In mode 0 it is also low while the receiver holds or is about to claim the shared pins. `tx_valid` may be held across cycles; nothing is taken until `tx_ready` is high.

The receive side is a valid/ready output stream. `rx_valid` stays high, with `rx_data`, `rx_bit9` and `frame_err` stable, until a cycle with `rx_ready` high. This back-pressure has a different effect in each mode:
- In the asynchronous modes, the line cannot be stalled. A frame that completes while the held frame is not being taken is dropped.
- In mode 0, the receiver does not start a new byte while `rx_valid` is high.

Top module: `serport4`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1, `rxd_oe` is 0, and `rx_valid`, `tx_done` and `frame_err` are 0.
- R2: A write is taken only when `tx_valid` and `tx_ready` are both high, and taking it clears `tx_done`. `tx_ready` is 0 while a frame is being sent. A `tx_valid` pulse during that time changes neither the frame on the line nor the idle line after it.
- R3: In mode 1 a frame is 10 bits: a start bit of 0, then `tx_data` bit 0 through bit 7, then a stop bit of 1.
- R4: In modes 2 and 3 a frame is 11 bits: a start bit of 0, then `tx_data` bit 0 through bit 7, then `tx_bit9`, then a stop bit of 1.
- R5: In mode 2 a bit lasts 32 clocks when `rate_half` is 0 and 16 clocks when it is 1. In modes 1 and 3 a bit lasts 16 `ext_tick` pulses.
- R6: In the asynchronous modes, `tx_done` rises at the start of the stop bit. It is 0 during the bit before the stop bit.
- R7: An asynchronous frame received while `rx_en` is 1 is delivered with `rx_valid` = 1 and `rx_data` = the data bits. `rx_bit9` is set as follows:
  - mode 1: the received stop bit;
  - modes 2 and 3: the received 9th bit.
- R8: `frame_err` is 1 together with a delivered frame whose stop bit was sampled as 0. It is 0 when the stop bit was 1, and it clears when the frame is taken.
- R9: A low pulse on `rxd_in` that has ended before mid-bit is treated as a false start and delivers nothing. With `rx_en` = 0, no asynchronous frame is received.
- R10: Each asynchronous bit is decided by a majority of three samples around mid-bit, so a one-clock glitch at mid-bit does not change the received value.
- R11: While `rx_valid` is 1 and `rx_ready` is 0, `rx_valid`, `rx_data` and `frame_err` hold. A frame that completes during that time is dropped. A cycle with `rx_ready` = 1 clears `rx_valid`.
- R12: A mode 0 transmit sends 8 bits, LSB first, with `rxd_oe` = 1 during the transfer. Each bit is 16 clocks. `txd` is low for the first half of each bit and rises at mid-bit, and `rxd_out` is valid at that rising edge. `txd` is high when no byte is being moved.
- R13: A mode 0 receive starts only when `rx_en` is 1, `rx_valid` is 0 and no transmit is in progress. It runs 8 shift clocks on `txd`, samples `rxd_in` at each rising edge of `txd` with the first bit as the LSB, and then sets `rx_valid`. `rx_bit9` and `frame_err` are 0 after a mode 0 receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 0 shift register, 1 async 8-bit, 2 async 9-bit fixed rate, 3 async 9-bit external rate |
| rate_half | input | 1 | Mode 2 rate select: 1 gives 16 clocks per bit, 0 gives 32 |
| ext_tick | input | 1 | Oversample pulse from an external timer, used in modes 1 and 3 |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| tx_data | input | 8 | Transmit data byte |
| tx_bit9 | input | 1 | 9th transmit bit for modes 2 and 3 |
| rx_en | input | 1 | Receive enable |
| rxd_in | input | 1 | Serial data pin, input side |
| txd | output | 1 | Serial output, or shift clock in mode 0 |
| rxd_out | output | 1 | Mode 0 serial data, output side |
| rxd_oe | output | 1 | Mode 0 output enable for the data pin |
| rx_valid | output | 1 | Received frame available |
| rx_ready | input | 1 | Consumer takes the received frame |
| rx_data | output | 8 | Received data byte |
| rx_bit9 | output | 1 | Received 9th bit (mode 1: stop bit) |
| tx_done | output | 1 | Transmit-done flag |
| frame_err | output | 1 | Stop bit of the held frame was 0 |

## Verification
Transmit frames are decoded from `txd` at mid-bit and looped back into the receiver. The stimulus mixes directed bytes with random bytes, random 9th bits, random modes and random external tick spacings, so a wrong bit order, a wrong frame length or a wrong rate shows up as a decode mismatch. Separate measurements of the start-bit length tell the two mode 2 rates and the tick-driven rate apart. Receive-only patterns apply a zero stop bit, a short low pulse, a one-clock mid-bit glitch and a second frame while the first is still held; these show whether each error path, the false-start filter, the vote and the back-pressure rule behave independently. Mode 0 is run in both directions with the shift clock edges timed, and the receive gating is checked by watching `txd` stay high.

// File: rtl/serport4_pkg.sv
package serport4_pkg;
  typedef enum logic [1:0] {
    SP_SHIFT    = 2'd0,
    SP_ASYNC8   = 2'd1,
    SP_ASYNC9_F = 2'd2,
    SP_ASYNC9_X = 2'd3
  } sp_mode_e;
endpackage

// File: rtl/serport4_baud.sv
// Oversample pulse source: one pulse per sixteenth of a bit in every mode.
module serport4_baud
  import serport4_pkg::*;
#(
  parameter int SLOW_DIV = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     rate_half,
  input  logic     ext_tick,
  output logic     os_tick
);
  logic slow_tick;

  generate
    if (SLOW_DIV > 1) begin : g_div
      localparam int DW = $clog2(SLOW_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           div_q <= '0;
        else if (div_q == DW'(SLOW_DIV - 1))  div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
      end
      assign slow_tick = (div_q == DW'(SLOW_DIV - 1));
    end else begin : g_nodiv
      assign slow_tick = 1'b1;
    end
  endgenerate

  always_comb begin
    unique case (mode)
      SP_SHIFT:    os_tick = 1'b1;
      SP_ASYNC9_F: os_tick = rate_half | slow_tick;
      default:     os_tick = ext_tick;
    endcase
  end

  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SP_ASYNC9_F && rate_half) |-> os_tick);
  p_half_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SP_ASYNC9_F && !rate_half && os_tick && SLOW_DIV > 1) |=>
      (!os_tick || mode != SP_ASYNC9_F || rate_half));
endmodule

// File: rtl/serport4_tx.sv
// Transmit shifter shared by all modes.
module serport4_tx
  import serport4_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_mode_e      mode,
  input  logic          os_tick,
  input  logic          rx_hold,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  output logic          busy,
  output logic          tx_done,
  output logic          line_out,
  output logic          sclk_out
);
  localparam int FW   = DW + 3;
  localparam int BW   = $clog2(FW + 1);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic          busy_q, sync_q, done_q;
  logic [FW-1:0] sh_q;
  logic [BW-1:0] bit_q, last_q;
  logic [CW-1:0] cnt_q;
  logic          accept, bit_end;

  assign tx_ready = !busy_q && !(mode == SP_SHIFT && rx_hold);
  assign accept   = tx_valid && tx_ready;
  assign bit_end  = busy_q && os_tick && (cnt_q == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sync_q <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      bit_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      sync_q <= (mode == SP_SHIFT);
      done_q <= 1'b0;
      bit_q  <= '0;
      cnt_q  <= '0;
      unique case (mode)
        SP_SHIFT: begin
          sh_q   <= {{(FW-DW){1'b1}}, tx_data};
          last_q <= BW'(DW - 1);
        end
        SP_ASYNC8: begin
          sh_q   <= {2'b11, tx_data, 1'b0};
          last_q <= BW'(DW + 1);
        end
        default: begin
          sh_q   <= {1'b1, tx_bit9, tx_data, 1'b0};
          last_q <= BW'(DW + 2);
        end
      endcase
    end else if (busy_q && os_tick) begin
      cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
      if (bit_end) begin
        if (bit_q == last_q) begin
          busy_q <= 1'b0;
          if (sync_q) done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= {1'b1, sh_q[FW-1:1]};
          if (!sync_q && bit_q == last_q - 1'b1) done_q <= 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign tx_done  = done_q;
  assign line_out = busy_q ? sh_q[0] : 1'b1;
  assign sclk_out = !(busy_q && sync_q && cnt_q < CW'(HALF));

  p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !tx_ready);
  p_done_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_done);
  p_done_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !sync_q && bit_q == last_q) |-> tx_done);
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode != SP_SHIFT) |=> !line_out);
endmodule

// File: rtl/serport4_rx.sv
// Receiver: 16x oversampled asynchronous path and mode 0 shift-in path.
module serport4_rx
  import serport4_pkg::*;
#(
  parameter int DW    = 8,
  parameter int OVS   = 16,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  sp_mode_e      mode,
  input  logic          os_tick,
  input  logic          rxd_in,
  input  logic          rx_en,
  input  logic          tx_busy,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          frame_err,
  output logic          busy,
  output logic          hold,
  output logic          sclk_out
);
  localparam int CW  = $clog2(OVS);
  localparam int BW  = $clog2(DW + 4);
  localparam int MID = OVS / 2;

  typedef enum logic [1:0] {R_IDLE, R_ASYNC, R_SYNC} rx_st_e;

  logic [SYNC-1:0] sy_q;
  logic            rxs, rxp_q;
  rx_st_e          st_q;
  logic [CW-1:0]   cnt_q;
  logic [BW-1:0]   bit_q;
  logic [DW-1:0]   sh_q;
  logic            s0_q, s1_q, nine_q, is9_q;
  logic            vote, at_vote, at_end;
  logic            start_async, start_sync, fin_async, fin_sync, space;
  logic            valid_q, bit9_q, ferr_q;
  logic [DW-1:0]   data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_q  <= '1;
      rxp_q <= 1'b1;
    end else begin
      sy_q  <= {sy_q[SYNC-2:0], rxd_in};
      rxp_q <= sy_q[SYNC-1];
    end
  end
  assign rxs = sy_q[SYNC-1];

  assign vote    = (s0_q & s1_q) | (s0_q & rxs) | (s1_q & rxs);
  assign at_vote = os_tick && cnt_q == CW'(MID + 1);
  assign at_end  = os_tick && cnt_q == CW'(OVS - 1);

  assign start_async = st_q == R_IDLE && mode != SP_SHIFT && rx_en && rxp_q && !rxs;
  assign start_sync  = st_q == R_IDLE && mode == SP_SHIFT && rx_en && !valid_q && !tx_busy;
  assign fin_async   = st_q == R_ASYNC && at_vote &&
                       bit_q == (is9_q ? BW'(DW + 2) : BW'(DW + 1));
  assign fin_sync    = st_q == R_SYNC && at_end && bit_q == BW'(DW - 1);
  assign space       = !valid_q || rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= R_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      s0_q   <= 1'b1;
      s1_q   <= 1'b1;
      nine_q <= 1'b0;
      is9_q  <= 1'b0;
    end else begin
      unique case (st_q)
        R_IDLE: begin
          if (start_async) begin
            st_q  <= R_ASYNC;
            cnt_q <= '0;
            bit_q <= '0;
            is9_q <= (mode != SP_ASYNC8);
          end else if (start_sync) begin
            st_q  <= R_SYNC;
            cnt_q <= '0;
            bit_q <= '0;
          end
        end
        R_ASYNC: if (os_tick) begin
          cnt_q <= at_end ? '0 : cnt_q + 1'b1;
          if (cnt_q == CW'(MID - 1)) s0_q <= rxs;
          if (cnt_q == CW'(MID))     s1_q <= rxs;
          if (at_vote) begin
            if (bit_q == '0) begin
              if (vote) st_q <= R_IDLE;
            end else if (bit_q <= BW'(DW)) begin
              sh_q <= {vote, sh_q[DW-1:1]};
            end else if (fin_async) begin
              st_q <= R_IDLE;
            end else begin
              nine_q <= vote;
            end
          end
          if (at_end) bit_q <= bit_q + 1'b1;
        end
        R_SYNC: if (os_tick) begin
          cnt_q <= at_end ? '0 : cnt_q + 1'b1;
          if (cnt_q == CW'(MID)) sh_q <= {rxs, sh_q[DW-1:1]};
          if (at_end) begin
            if (bit_q == BW'(DW - 1)) st_q <= R_IDLE;
            else                      bit_q <= bit_q + 1'b1;
          end
        end
        default: st_q <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      bit9_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else if ((fin_async || fin_sync) && space) begin
      valid_q <= 1'b1;
      data_q  <= sh_q;
      bit9_q  <= fin_sync ? 1'b0 : (is9_q ? nine_q : vote);
      ferr_q  <= fin_async && !vote;
    end else if (rx_ready) begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end
  end

  assign rx_valid  = valid_q;
  assign rx_data   = data_q;
  assign rx_bit9   = bit9_q;
  assign frame_err = ferr_q;
  assign busy      = st_q != R_IDLE;
  assign hold      = busy || start_sync;
  assign sclk_out  = !(st_q == R_SYNC && cnt_q < CW'(MID));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rx_ready) |=> (valid_q && $stable(data_q) && $stable(ferr_q)));
  p_ferr_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> valid_q);
  p_sync_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == R_IDLE && mode == SP_SHIFT && (valid_q || !rx_en)) |=> st_q != R_SYNC);
endmodule

// File: rtl/serport4.sv
module serport4
  import serport4_pkg::*;
#(
  parameter int DW       = 8,
  parameter int OVS      = 16,
  parameter int SYNC     = 2,
  parameter int SLOW_DIV = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          rate_half,
  input  logic          ext_tick,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic          rx_en,
  input  logic          rxd_in,
  output logic          txd,
  output logic          rxd_out,
  output logic          rxd_oe,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          tx_done,
  output logic          frame_err
);
  sp_mode_e mode_e;
  logic     os_tick, tx_busy, rx_busy, rx_hold;
  logic     tx_line, tx_sclk, rx_sclk;

  assign mode_e = sp_mode_e'(mode);

  serport4_baud #(.SLOW_DIV(SLOW_DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .rate_half(rate_half),
    .ext_tick(ext_tick), .os_tick(os_tick)
  );

  serport4_tx #(.DW(DW), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .os_tick(os_tick),
    .rx_hold(rx_hold), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .busy(tx_busy),
    .tx_done(tx_done), .line_out(tx_line), .sclk_out(tx_sclk)
  );

  serport4_rx #(.DW(DW), .OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .os_tick(os_tick),
    .rxd_in(rxd_in), .rx_en(rx_en), .tx_busy(tx_busy),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .frame_err(frame_err), .busy(rx_busy),
    .hold(rx_hold), .sclk_out(rx_sclk)
  );

  assign txd     = (mode_e == SP_SHIFT) ? (tx_sclk & rx_sclk) : tx_line;
  assign rxd_out = tx_line;
  assign rxd_oe  = (mode_e == SP_SHIFT) && tx_busy;

  p_idle_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == SP_SHIFT && !tx_busy && !rx_busy) |-> txd);
  p_one_user_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_e == SP_SHIFT) |-> !(tx_busy && rx_busy && $stable(mode)));
endmodule

// File: tb/serport4_test.sv
module serport4_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, rate_half, tx_valid, tx_bit9, rx_en, rx_ready, lb, drv;
  logic       ext_tick = 1'b0;
  logic [1:0] mode;
  logic [7:0] tx_data;
  logic       tx_ready, txd, rxd_out, rxd_oe, rx_valid, rx_bit9, tx_done, frame_err;
  logic [7:0] rx_data;
  logic       rxd_in;
  assign rxd_in = lb ? txd : drv;

  int errs = 0, checks = 0, kext = 1, tcnt = 0;
  bit finished = 0;

  serport4 uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_half(rate_half), .ext_tick(ext_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .rx_en(rx_en), .rxd_in(rxd_in), .txd(txd), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_bit9(rx_bit9),
    .tx_done(tx_done), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (tcnt >= kext - 1) begin tcnt <= 0; ext_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; ext_tick <= 1'b0; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bitp(int m, bit rh);
    if (m == 0) return 16;
    if (m == 2) return rh ? 16 : 32;
    return 16 * kext;
  endfunction

  function automatic int nbits(int m);
    return (m == 1) ? 10 : 11;
  endfunction

  function automatic logic [10:0] mk_frame(int m, logic [7:0] d, logic b9, logic stop);
    if (m == 1) return {1'b1, stop, d, 1'b0};
    return {stop, b9, d, 1'b0};
  endfunction

  task automatic do_write(input logic [7:0] d, input logic b9);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_bit9 = b9; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic consume();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic capture(input int n, input int p, output logic [10:0] got,
                         output logic dprev, output logic dlast);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (p / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i == n - 2) dprev = tx_done;
      if (i == n - 1) dlast = tx_done;
      if (i < n - 1) repeat (p) @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [10:0] f, input int n, input int p, input int gbit);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < p; c++) begin
        drv = f[i];
        if (i == gbit && c == p / 2) drv = ~f[i];
        @(negedge clk);
      end
    end
    drv = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic async_loop(input int m, input bit rh, input logic [7:0] d, input logic b9);
    logic [10:0] got, expf;
    logic dp, dl;
    int p, n;
    mode = 2'(m); rate_half = rh; lb = 1'b1;
    p = bitp(m, rh); n = nbits(m);
    expf = mk_frame(m, d, b9, 1'b1);
    do_write(d, b9);
    chk(tx_done == 1'b0, "R2 done cleared on write", tx_done, 0);
    capture(n, p, got, dp, dl);
    if (m == 1) chk(got[9:0] == expf[9:0], "R3 mode1 frame", got, expf);
    else        chk(got == expf, "R4 9-bit frame", got, expf);
    chk(dp == 1'b0 && dl == 1'b1, "R6 done at stop", {dp, dl}, 2'b01);
    repeat (p) @(negedge clk);
    chk(rx_valid && rx_data == d, "R7 loopback data", rx_data, d);
    chk(rx_bit9 == ((m == 1) ? 1'b1 : b9), "R7 ninth bit", rx_bit9, (m == 1) ? 1'b1 : b9);
    chk(frame_err == 1'b0, "R8 no framing error", frame_err, 0);
    consume();
    chk(rx_valid == 1'b0, "R11 taken", rx_valid, 0);
    wait_idle();
    lb = 1'b0;
  endtask

  task automatic measure_start(input int m, input bit rh, input int expn, input int tol);
    int cnt;
    mode = 2'(m); rate_half = rh; lb = 1'b0;
    do_write(8'h01, 1'b0);
    cnt = 0;
    while (txd == 1'b0) begin cnt++; @(negedge clk); end
    chk(cnt >= expn - tol && cnt <= expn + tol, "R5 bit length", cnt, expn);
    wait_idle();
  endtask

  task automatic m0_tx(input logic [7:0] d);
    logic pv;
    int per, t;
    mode = 2'd0; lb = 1'b0; rx_en = 1'b0;
    do_write(d, 1'b0);
    per = 0; t = 0;
    for (int i = 0; i < 8; i++) begin
      pv = txd;
      @(negedge clk); t++;
      while (!(pv == 1'b0 && txd == 1'b1)) begin pv = txd; @(negedge clk); t++; end
      chk(rxd_oe == 1'b1 && rxd_out == d[i], "R12 shift data bit", {rxd_oe, rxd_out}, {1'b1, d[i]});
      if (i == 1) per = t;
      t = 0;
    end
    chk(per == 16, "R12 shift clock period", per, 16);
    wait_idle();
    chk(tx_done == 1'b1 && txd == 1'b1 && rxd_oe == 1'b0, "R12 idle after byte",
        {tx_done, txd, rxd_oe}, 3'b110);
  endtask

  task automatic m0_rx(input logic [7:0] d);
    logic pv;
    int guard, lows;
    mode = 2'd0; lb = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      pv = txd;
      @(negedge clk);
      while (!(pv == 1'b1 && txd == 1'b0)) begin pv = txd; @(negedge clk); end
      drv = d[i];
    end
    guard = 0;
    while (!rx_valid && guard < 100) begin guard++; @(negedge clk); end
    chk(rx_valid && rx_data == d, "R13 shift-in data", rx_data, d);
    chk(rx_bit9 == 1'b0 && frame_err == 1'b0, "R13 flags", {rx_bit9, frame_err}, 0);
    lows = 0;
    repeat (40) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R13 no start while held", lows, 0);
    rx_en = 1'b0; drv = 1'b1;
    consume();
  endtask

  initial begin
    logic [7:0] d;
    logic b, rh;
    int m, lows;
    void'($urandom(32'h5e1a_4c07));
    rst_n = 0; mode = 2'd1; rate_half = 0; tx_valid = 0; tx_bit9 = 0;
    rx_en = 0; rx_ready = 0; lb = 0; drv = 1; tx_data = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1 && tx_ready == 1 && rxd_oe == 0, "R1 line reset", {txd, tx_ready, rxd_oe}, 3'b110);
    chk(rx_valid == 0 && tx_done == 0 && frame_err == 0, "R1 flags reset",
        {rx_valid, tx_done, frame_err}, 0);
    rx_en = 1;

    kext = 1; async_loop(1, 0, 8'hA5, 1'b0);
    async_loop(2, 1, 8'h3C, 1'b1);
    async_loop(2, 0, 8'hC3, 1'b0);
    kext = 2; async_loop(3, 0, 8'h96, 1'b1);

    measure_start(2, 0, 32, 1);
    measure_start(2, 1, 16, 1);
    kext = 3; measure_start(3, 0, 48, 3);
    kext = 1;

    // R2: offer while busy is ignored
    mode = 2'd1; lb = 0;
    begin
      logic [10:0] got, expf;
      logic dp, dl;
      do_write(8'h3C, 1'b0);
      chk(tx_ready == 1'b0, "R2 not ready while sending", tx_ready, 0);
      tx_data = 8'hFF; tx_valid = 1'b1;
      @(negedge clk) tx_valid = 1'b0;
      capture(10, 16, got, dp, dl);
      expf = mk_frame(1, 8'h3C, 1'b0, 1'b1);
      chk(got[9:0] == expf[9:0], "R2 frame unchanged", got, expf);
      wait_idle();
      lows = 0;
      repeat (40) begin @(negedge clk); if (!txd) lows++; end
      chk(lows == 0, "R2 no extra frame", lows, 0);
    end

    // R8: zero stop bit, mode 1 (stop lands in rx_bit9)
    mode = 2'd1; kext = 1;
    drive_frame(mk_frame(1, 8'h5B, 1'b0, 1'b0), 10, 16, -1);
    chk(rx_valid && frame_err == 1'b1, "R8 framing error", frame_err, 1);
    chk(rx_data == 8'h5B && rx_bit9 == 1'b0, "R7 mode1 stop into bit9", {rx_bit9, rx_data}, 9'h05B);
    consume();
    chk(frame_err == 1'b0 && rx_valid == 1'b0, "R8 cleared on take", {frame_err, rx_valid}, 0);

    // R9: false start then a real frame
    mode = 2'd2; rate_half = 1;
    drv = 0; repeat (4) @(negedge clk); drv = 1;
    repeat (60) @(negedge clk);
    chk(rx_valid == 1'b0, "R9 false start ignored", rx_valid, 0);
    drive_frame(mk_frame(2, 8'hE1, 1'b1, 1'b1), 11, 16, -1);
    chk(rx_valid && rx_data == 8'hE1 && rx_bit9, "R9 frame after false start", rx_data, 8'hE1);
    consume();

    // R9: rx_en low
    rx_en = 0;
    drive_frame(mk_frame(2, 8'h77, 1'b0, 1'b1), 11, 16, -1);
    chk(rx_valid == 1'b0, "R9 disabled receiver", rx_valid, 0);
    rx_en = 1;

    // R10: one-clock glitches at mid-bit
    drive_frame(mk_frame(2, 8'h5A, 1'b1, 1'b1), 11, 16, 3);
    chk(rx_valid && rx_data == 8'h5A, "R10 glitch on data bit", rx_data, 8'h5A);
    consume();
    drive_frame(mk_frame(2, 8'h0F, 1'b0, 1'b1), 11, 16, 9);
    chk(rx_valid && rx_data == 8'h0F && rx_bit9 == 1'b0, "R10 glitch on ninth bit",
        {rx_bit9, rx_data}, 9'h00F);
    consume();

    // R11: second frame dropped while first held
    drive_frame(mk_frame(2, 8'h11, 1'b1, 1'b1), 11, 16, -1);
    drive_frame(mk_frame(2, 8'h22, 1'b0, 1'b0), 11, 16, -1);
    chk(rx_valid && rx_data == 8'h11 && rx_bit9 && !frame_err, "R11 held frame kept",
        {frame_err, rx_bit9, rx_data}, 10'h111);
    consume();
    chk(rx_valid == 1'b0, "R11 cleared by ready", rx_valid, 0);

    // random loopback frames
    for (int k = 0; k < 6; k++) begin
      m = 1 + int'($urandom_range(2));
      rh = 1'($urandom_range(1));
      kext = 1 + int'($urandom_range(2));
      d = 8'($urandom);
      b = 1'($urandom_range(1));
      async_loop(m, rh, d, b);
    end
    kext = 1;

    // mode 0
    rx_en = 0; mode = 2'd0;
    lows = 0;
    repeat (40) begin @(negedge clk); if (!txd) lows++; end
    chk(lows == 0, "R13 no shift-in while disabled", lows, 0);
    m0_tx(8'hB4);
    m0_tx(8'($urandom));
    m0_rx(8'h6D);
    m0_rx(8'($urandom) | 8'h80);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule